// File: doc/BRIEF.md
# Color-Key Pixel Source Selector

This block sits in a pixel pipeline and decides, pixel by pixel, whether the palette path or the direct-color path is shown. Each pixel carries a palette index and three direct-color components. The index comes either from the overlay port or from a pass-through port. All four values are brought to a common width and then tested against programmable inclusive ranges. A small control word can force any channel's test to pass and can invert the combined result. An external window-match input can also force the palette path.

Configuration is written through a plain address/data/write-enable bus. The decision and the chosen pixel word are registered on the pixel clock with a fixed latency of one cycle, and the input valid flag is delayed to stay aligned with them. Palette lookup, digital-to-analog conversion and the window comparator itself are outside this block.

Top module: `ckey_pixel_select`

## Requirements
- R1: A channel matches only when its low bound ≤ its normalized value ≤ its high bound, and both bounds count as inside.
- R2: Control bits 0, 1, 2 and 3 force a pass for the palette, red, green and blue channels respectively. The key is the AND over the four channels of (match OR force), XORed with control bit 4.
- R3: After reset every low bound is 0xFF, every high bound is 0x00 and the control word is 0x10. The output register holds palette=1, valid=0 and pixel=0, and any pixel presented with these settings selects palette.
- R4: A channel whose low bound is greater than its high bound never matches.
- R5: When vga_sel is 1, the palette channel compares vga_pix AND read_mask, and that value is the palette index. When vga_sel is 0, the palette channel uses the overlay value.
- R6: Overlay data of width w (width code 1..8, where code 0 or a code above 8 means 8) keeps its low w bits in place. The remaining upper bits come from page_reg, and the result is ANDed with read_mask.
- R7: A direct-color component of width w (same width code rule) moves its low w bits to the top of the byte and fills the low bits with zero. Input bits above w are ignored.
- R8: The palette path is selected whenever win_match is 1 or the key is 1.
- R9: A write stores cfg_wdata at address 2k (low bound) or 2k+1 (high bound), where k is 0 for palette, 1 for red, 2 for green and 3 for blue. Address 8 takes bits 4:0 as the control word. Writes to addresses 9 to 15 change nothing.
- R10: The outputs reflect the pixel sampled on the previous clock edge. out_valid is the previous pix_valid. out_pix is {16'h0, palette index} when palette is selected, and {red, green, blue} normalized otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| vga_sel | input | 1 | Picks the pass-through port as the palette source |
| page_reg | input | 8 | Page bits that fill the upper part of a narrow overlay index |
| read_mask | input | 8 | Mask applied to the palette index |
| ovl_width | input | 4 | Overlay width code |
| dc_width | input | 4 | Direct-color component width code |
| pix_valid | input | 1 | Input pixel valid |
| ovl_pix | input | 8 | Overlay index, right-aligned |
| vga_pix | input | 8 | Pass-through palette index |
| red_pix | input | 8 | Red component, right-aligned |
| grn_pix | input | 8 | Green component, right-aligned |
| blu_pix | input | 8 | Blue component, right-aligned |
| win_match | input | 1 | External window match, forces palette |
| out_valid | output | 1 | Delayed pixel valid |
| out_palette | output | 1 | 1 = palette path shown, 0 = direct color |
| out_pix | output | 24 | Selected pixel word |

## Verification
The bench builds the block with its default parameters: 8-bit components, a 4-bit address and NCH fixed at four channels. With these values every width code from 0 to 15 can be driven, including the codes that fall back to full width. Every bound can sit at the exact edges 0x00 and 0xFF, and all sixteen force patterns can be written, together with empty and single-value ranges. The bench also uses the whole address space, so unmapped addresses 9 to 15 can be written and then observed to have no effect on the selection.

// File: rtl/ckey_pkg.sv
package ckey_pkg;

  localparam int NCH = 4;

  // channel order fixes the control-bit positions
  typedef enum logic [1:0] {
    CH_PAL = 2'd0,
    CH_RED = 2'd1,
    CH_GRN = 2'd2,
    CH_BLU = 2'd3
  } chan_e;

  typedef struct packed {
    logic           invert;
    logic [NCH-1:0] force_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{invert: 1'b1, force_en: '0};

  function automatic logic key_eval(logic [NCH-1:0] match, ctrl_t c);
    return (&(match | c.force_en)) ^ c.invert;
  endfunction

endpackage

// File: rtl/ckey_regs.sv
module ckey_regs
  import ckey_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  output logic [NCH-1:0][DW-1:0]  lo_q,
  output logic [NCH-1:0][DW-1:0]  hi_q,
  output ctrl_t                   ctrl_q
);

  localparam int CTRL_ADDR = 2 * NCH;
  localparam int CW        = $bits(ctrl_t);

  logic [NCH-1:0] lo_hit;
  logic [NCH-1:0] hi_hit;
  logic           ctrl_hit;
  logic [DW-CW-1:0] ctrl_unused_bits;

  assign ctrl_hit         = wr_en && (wr_addr == AW'(CTRL_ADDR));
  assign ctrl_unused_bits = wr_data[DW-1:CW];

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [DW-1:0] lo_r;
    logic [DW-1:0] hi_r;

    assign lo_hit[k] = wr_en && (wr_addr == AW'(2 * k));
    assign hi_hit[k] = wr_en && (wr_addr == AW'(2 * k + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_r <= '1;
        hi_r <= '0;
      end else begin
        if (lo_hit[k]) lo_r <= wr_data;
        if (hi_hit[k]) hi_r <= wr_data;
      end
    end

    assign lo_q[k] = lo_r;
    assign hi_q[k] = hi_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= CTRL_RST;
    else if (ctrl_hit) ctrl_q <= ctrl_t'(wr_data[CW-1:0]);
  end

  // R9: at most one register is addressed by any write
  a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lo_hit, hi_hit, ctrl_hit}));

  // R9: a control write lands in the control register
  a_r9_ctrl_update: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |=> (ctrl_q == ctrl_t'($past(wr_data[CW-1:0]))));

  // R9: an unmapped write leaves the control word unchanged
  a_r9_unmapped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr > AW'(CTRL_ADDR))) |=> $stable(ctrl_q));

endmodule

// File: rtl/ckey_normalize.sv
module ckey_normalize #(
  parameter int DW  = 8,
  parameter int WCW = 4
) (
  input  logic            vga_sel,
  input  logic [WCW-1:0]  ovl_width,
  input  logic [WCW-1:0]  dc_width,
  input  logic [DW-1:0]   page_reg,
  input  logic [DW-1:0]   read_mask,
  input  logic [DW-1:0]   ovl_pix,
  input  logic [DW-1:0]   vga_pix,
  input  logic [DW-1:0]   red_pix,
  input  logic [DW-1:0]   grn_pix,
  input  logic [DW-1:0]   blu_pix,
  output logic [DW-1:0]   pal_idx,
  output logic [DW-1:0]   red_n,
  output logic [DW-1:0]   grn_n,
  output logic [DW-1:0]   blu_n
);

  // width code: 0 or above DW means full width
  function automatic int width_of(logic [WCW-1:0] code);
    if (code == '0 || int'(code) > DW) return DW;
    return int'(code);
  endfunction

  function automatic logic [DW-1:0] low_mask(logic [WCW-1:0] code);
    logic [DW:0] one_up;
    one_up = {{DW{1'b0}}, 1'b1} << width_of(code);
    return DW'(one_up - 1'b1);
  endfunction

  function automatic logic [DW-1:0] left_align(logic [DW-1:0] c,
                                               logic [WCW-1:0] code);
    return DW'((c & low_mask(code)) << (DW - width_of(code)));
  endfunction

  function automatic logic [DW-1:0] pal_pack(logic [DW-1:0] ovl,
                                             logic [DW-1:0] page,
                                             logic [WCW-1:0] code);
    logic [DW-1:0] m;
    m = low_mask(code);
    return (ovl & m) | (page & ~m);
  endfunction

  logic [DW-1:0] ovl_packed;
  logic [DW-1:0] dc_low_mask;

  assign ovl_packed  = pal_pack(ovl_pix, page_reg, ovl_width);
  assign pal_idx     = (vga_sel ? vga_pix : ovl_packed) & read_mask;
  assign red_n       = left_align(red_pix, dc_width);
  assign grn_n       = left_align(grn_pix, dc_width);
  assign blu_n       = left_align(blu_pix, dc_width);
  assign dc_low_mask = ~DW'(low_mask(dc_width) << (DW - width_of(dc_width)));

  always_comb begin
    // R7: the vacated low bits of every component are zero
    a_r7_low_zero: assert (((red_n | grn_n | blu_n) & dc_low_mask) == '0)
      else $error("R7 low bits not zero");
    // R6: overlay upper bits come from the page register
    if (!vga_sel) begin
      a_r6_page_fill: assert ((pal_idx & ~low_mask(ovl_width)) ==
                              (page_reg & read_mask & ~low_mask(ovl_width)))
        else $error("R6 page fill wrong");
    end
    // R5: nothing outside read_mask reaches the index
    a_r5_mask_applied: assert ((pal_idx & ~read_mask) == '0)
      else $error("R5 mask not applied");
  end

endmodule

// File: rtl/ckey_range_cmp.sv
module ckey_range_cmp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] val,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  output logic          match
);

  logic above_lo;
  logic below_hi;

  assign above_lo = (val >= lo);
  assign below_hi = (val <= hi);
  assign match    = above_lo && below_hi;

  always_comb begin
    // R4: an inverted range holds no value
    if (lo > hi) begin
      a_r4_empty_range: assert (!match) else $error("R4 empty range matched");
    end
  end

endmodule

// File: rtl/ckey_pixel_select.sv
module ckey_pixel_select
  import ckey_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  localparam int WCW = $clog2(DW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              vga_sel,
  input  logic [DW-1:0]     page_reg,
  input  logic [DW-1:0]     read_mask,
  input  logic [WCW-1:0]    ovl_width,
  input  logic [WCW-1:0]    dc_width,
  input  logic              pix_valid,
  input  logic [DW-1:0]     ovl_pix,
  input  logic [DW-1:0]     vga_pix,
  input  logic [DW-1:0]     red_pix,
  input  logic [DW-1:0]     grn_pix,
  input  logic [DW-1:0]     blu_pix,
  input  logic              win_match,
  output logic              out_valid,
  output logic              out_palette,
  output logic [3*DW-1:0]   out_pix
);

  localparam int PW = 3 * DW;

  logic [NCH-1:0][DW-1:0] lo_q;
  logic [NCH-1:0][DW-1:0] hi_q;
  ctrl_t                  ctrl;
  logic [NCH-1:0][DW-1:0] cmp_val;
  logic [NCH-1:0]         ch_match;
  logic [DW-1:0]          pal_idx, red_n, grn_n, blu_n;
  logic                   key_hit;
  logic                   pick_pal;
  logic [PW-1:0]          pix_next;

  ckey_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .lo_q    (lo_q),
    .hi_q    (hi_q),
    .ctrl_q  (ctrl)
  );

  ckey_normalize #(.DW(DW), .WCW(WCW)) u_norm (
    .vga_sel   (vga_sel),
    .ovl_width (ovl_width),
    .dc_width  (dc_width),
    .page_reg  (page_reg),
    .read_mask (read_mask),
    .ovl_pix   (ovl_pix),
    .vga_pix   (vga_pix),
    .red_pix   (red_pix),
    .grn_pix   (grn_pix),
    .blu_pix   (blu_pix),
    .pal_idx   (pal_idx),
    .red_n     (red_n),
    .grn_n     (grn_n),
    .blu_n     (blu_n)
  );

  assign cmp_val[CH_PAL] = pal_idx;
  assign cmp_val[CH_RED] = red_n;
  assign cmp_val[CH_GRN] = grn_n;
  assign cmp_val[CH_BLU] = blu_n;

  for (genvar k = 0; k < NCH; k++) begin : g_cmp
    ckey_range_cmp #(.DW(DW)) u_cmp (
      .val   (cmp_val[k]),
      .lo    (lo_q[k]),
      .hi    (hi_q[k]),
      .match (ch_match[k])
    );

    // R1: a reported match lies inside the inclusive bounds
    a_r1_match_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      ch_match[k] |-> (cmp_val[k] >= lo_q[k] && cmp_val[k] <= hi_q[k]));
  end

  assign key_hit  = key_eval(ch_match, ctrl);
  assign pick_pal = win_match | key_hit;
  assign pix_next = pick_pal ? {{(2*DW){1'b0}}, pal_idx}
                             : {red_n, grn_n, blu_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_palette <= 1'b1;
      out_pix     <= '0;
    end else begin
      out_valid   <= pix_valid;
      out_palette <= pick_pal;
      out_pix     <= pix_next;
    end
  end

  // R8: a window match always shows the palette path one cycle later
  a_r8_window_forces: assert property (@(posedge clk) disable iff (!rst_n)
    win_match |=> out_palette);

  // R2: all channels forced leaves only the inversion bit in control
  a_r2_all_forced: assert property (@(posedge clk) disable iff (!rst_n)
    ((&ctrl.force_en) && !win_match) |=> (out_palette == !$past(ctrl.invert)));

  // R10: valid travels with one register of delay
  a_r10_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  // R10: palette words carry nothing above the index
  a_r10_pal_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_palette |-> (out_pix[PW-1:DW] == '0));

  // R3: the first cycle out of reset shows the palette path
  a_r3_reset_palette: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_palette && !out_valid));

endmodule

// File: tb/ckey_pixel_select_test.sv
`timescale 1ns/1ps
module ckey_pixel_select_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        vga_sel = 1'b0;
  logic [7:0]  page_reg = '0, read_mask = 8'hFF;
  logic [3:0]  ovl_width = '0, dc_width = '0;
  logic        pix_valid = 1'b0;
  logic [7:0]  ovl_pix = '0, vga_pix = '0, red_pix = '0, grn_pix = '0, blu_pix = '0;
  logic        win_match = 1'b0;
  logic        out_valid, out_palette;
  logic [23:0] out_pix;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ckey_pixel_select uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .vga_sel(vga_sel), .page_reg(page_reg),
    .read_mask(read_mask), .ovl_width(ovl_width), .dc_width(dc_width),
    .pix_valid(pix_valid), .ovl_pix(ovl_pix), .vga_pix(vga_pix),
    .red_pix(red_pix), .grn_pix(grn_pix), .blu_pix(blu_pix),
    .win_match(win_match), .out_valid(out_valid), .out_palette(out_palette),
    .out_pix(out_pix)
  );

  // bench copy of the programmed configuration
  logic [7:0] sh_lo [4];
  logic [7:0] sh_hi [4];
  logic [4:0] sh_ctrl;

  typedef struct packed {
    logic       vm;
    logic [3:0] ow;
    logic [7:0] ovl;
    logic [7:0] vga;
    logic [7:0] page;
    logic [7:0] mask;
    logic [3:0] dw;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
    logic       win;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd8, 8'h15, 8'h00, 8'h00, 8'hFF, 4'd8, 8'h90, 8'h33, 8'h40, 1'b0},
    '{1'b0, 4'd8, 8'h15, 8'h00, 8'h00, 8'hFF, 4'd8, 8'h90, 8'h33, 8'h41, 1'b0},
    '{1'b0, 4'd4, 8'hE5, 8'h00, 8'h13, 8'hFF, 4'd5, 8'hF2, 8'h07, 8'h08, 1'b0},
    '{1'b0, 4'd4, 8'h05, 8'h00, 8'h30, 8'hFF, 4'd5, 8'h12, 8'h07, 8'h08, 1'b0},
    '{1'b1, 4'd2, 8'h00, 8'h20, 8'h00, 8'hFF, 4'd8, 8'h80, 8'h00, 8'h40, 1'b0},
    '{1'b1, 4'd2, 8'h00, 8'h21, 8'h00, 8'hFF, 4'd8, 8'h80, 8'h00, 8'h40, 1'b0},
    '{1'b0, 4'd8, 8'h1A, 8'h00, 8'h00, 8'h0F, 4'd8, 8'h9F, 8'hFF, 8'h40, 1'b0},
    '{1'b0, 4'd8, 8'h55, 8'h00, 8'h00, 8'hFF, 4'd8, 8'h10, 8'h10, 8'h10, 1'b1},
    '{1'b0, 4'd8, 8'h10, 8'h00, 8'h00, 8'hFF, 4'd1, 8'h01, 8'hFE, 8'h01, 1'b0},
    '{1'b0, 4'd0, 8'h10, 8'h00, 8'hFF, 8'hFF, 4'd12, 8'h9F, 8'h00, 8'h40, 1'b0}
  };

  function automatic int wbits(logic [3:0] code);
    return (code == 0 || code > 8) ? 8 : int'(code);
  endfunction

  function automatic logic [7:0] m_pal(logic vm, logic [3:0] ow, logic [7:0] ovl,
                                       logic [7:0] vga, logic [7:0] page,
                                       logic [7:0] mask);
    logic [7:0] t;
    int w = wbits(ow);
    for (int i = 0; i < 8; i++) t[i] = vm ? vga[i] : ((i < w) ? ovl[i] : page[i]);
    return t & mask;
  endfunction

  function automatic logic [7:0] m_dc(logic [3:0] dw, logic [7:0] c);
    logic [7:0] t = '0;
    int w = wbits(dw);
    for (int i = 0; i < w; i++) t[8 - w + i] = c[i];
    return t;
  endfunction

  function automatic logic inside_rng(logic [7:0] v, logic [7:0] lo, logic [7:0] hi);
    return !(v < lo) && !(v > hi);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (a < 8) begin
      if (a[0]) sh_hi[a[3:1]] = d; else sh_lo[a[3:1]] = d;
    end else if (a == 8) sh_ctrl = d[4:0];
  endtask

  // drive one pixel, then check outputs one edge later
  task automatic pixel(string tag, vec_t v, logic vld);
    logic [7:0] p, r, g, b;
    logic [3:0] m;
    logic key, sel;
    vga_sel = v.vm; ovl_width = v.ow; ovl_pix = v.ovl; vga_pix = v.vga;
    page_reg = v.page; read_mask = v.mask; dc_width = v.dw;
    red_pix = v.r; grn_pix = v.g; blu_pix = v.b; win_match = v.win;
    pix_valid = vld;
    p = m_pal(v.vm, v.ow, v.ovl, v.vga, v.page, v.mask);
    r = m_dc(v.dw, v.r); g = m_dc(v.dw, v.g); b = m_dc(v.dw, v.b);
    m[0] = inside_rng(p, sh_lo[0], sh_hi[0]) || sh_ctrl[0];
    m[1] = inside_rng(r, sh_lo[1], sh_hi[1]) || sh_ctrl[1];
    m[2] = inside_rng(g, sh_lo[2], sh_hi[2]) || sh_ctrl[2];
    m[3] = inside_rng(b, sh_lo[3], sh_hi[3]) || sh_ctrl[3];
    key = (m == 4'hF) ? !sh_ctrl[4] : sh_ctrl[4];
    sel = v.win || key;
    @(negedge clk);
    check({tag, " select"}, 32'(out_palette), 32'(sel));
    check({tag, " pixel"}, 32'(out_pix), sel ? {24'h0, p} : {8'h0, r, g, b});
    check({tag, " valid R10"}, 32'(out_valid), 32'(vld));
  endtask

  function automatic vec_t mk(logic vm, logic [7:0] pal, logic [7:0] r,
                              logic [7:0] g, logic [7:0] b, logic win);
    return '{vm, 4'd8, pal, pal, 8'h00, 8'hFF, 4'd8, r, g, b, win};
  endfunction

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 4; k++) begin sh_lo[k] = 8'hFF; sh_hi[k] = 8'h00; end
    sh_ctrl = 5'h10;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R3: reset state of the output register
    check("R3 reset palette", 32'(out_palette), 32'd1);
    check("R3 reset valid", 32'(out_valid), 32'd0);
    check("R3 reset pixel", 32'(out_pix), 32'd0);
    rst_n = 1'b1;
    // R3: default ranges are empty and inverted, so palette is shown
    pixel("R3 default keys palette", mk(1'b0, 8'h10, 8'h90, 8'h00, 8'h40, 1'b0), 1'b1);
    pixel("R3 default keys palette b", mk(1'b0, 8'hFF, 8'h00, 8'hFF, 8'h00, 1'b0), 1'b1);

    // R9: program ranges and control
    wr(4'd0, 8'h10); wr(4'd1, 8'h20);
    wr(4'd2, 8'h80); wr(4'd3, 8'h9F);
    wr(4'd4, 8'h00); wr(4'd5, 8'hFF);
    wr(4'd6, 8'h40); wr(4'd7, 8'h40);
    wr(4'd8, 8'h00);

    // table walk: R2 R5 R6 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      pixel($sformatf("R2 R5 R6 R7 R8 vector %0d", i), VECS[i], (i % 3) != 2);
    end

    // R1: inclusive bounds on the palette channel, others forced
    wr(4'd8, 8'h0E);
    pixel("R1 at low bound", mk(1'b0, 8'h10, 8'h00, 8'h00, 8'h00, 1'b0), 1'b1);
    pixel("R1 below low bound", mk(1'b0, 8'h0F, 8'h00, 8'h00, 8'h00, 1'b0), 1'b1);
    pixel("R1 at high bound", mk(1'b0, 8'h20, 8'h00, 8'h00, 8'h00, 1'b0), 1'b1);
    pixel("R1 above high bound", mk(1'b0, 8'h21, 8'h00, 8'h00, 8'h00, 1'b0), 1'b1);

    // R4: inverted red range never matches
    wr(4'd2, 8'h50); wr(4'd3, 8'h40); wr(4'd8, 8'h0D);
    pixel("R4 inside gap", mk(1'b0, 8'h00, 8'h45, 8'h00, 8'h00, 1'b0), 1'b1);
    pixel("R4 at low value", mk(1'b0, 8'h00, 8'h50, 8'h00, 8'h00, 1'b0), 1'b1);
    pixel("R4 at high value", mk(1'b0, 8'h00, 8'h40, 8'h00, 8'h00, 1'b0), 1'b1);

    // R2: all forced, inversion decides
    wr(4'd8, 8'h1F);
    pixel("R2 forced inverted", mk(1'b0, 8'h77, 8'h01, 8'h02, 8'h03, 1'b0), 1'b1);
    // R8: window overrides a zero key
    pixel("R8 window override", mk(1'b0, 8'h77, 8'h01, 8'h02, 8'h03, 1'b1), 1'b1);
    // R9: unmapped writes leave the key unchanged
    wr(4'd9, 8'h0F); wr(4'd15, 8'h0F); wr(4'd12, 8'h0F);
    pixel("R9 unmapped ignored", mk(1'b0, 8'h77, 8'h01, 8'h02, 8'h03, 1'b0), 1'b1);
    check("R9 unmapped keeps direct", 32'(out_palette), 32'd0);
    wr(4'd8, 8'h0F);
    pixel("R2 forced plain", mk(1'b0, 8'h77, 8'h01, 8'h02, 8'h03, 1'b0), 1'b1);
    check("R2 forced plain palette", 32'(out_palette), 32'd1);

    // R10: valid low passes through
    pixel("R10 invalid pixel", mk(1'b1, 8'h33, 8'h01, 8'h02, 8'h03, 1'b0), 1'b0);
    pixel("R10 valid again", mk(1'b1, 8'h33, 8'h01, 8'h02, 8'h03, 1'b0), 1'b1);

    finish_run();
  end

endmodule